// File: doc/BRIEF.md
# Predicated Element-Width Register Writer

This block takes one vector element result per cycle and writes it into a 32-entry, 64-bit register file, with no read-modify-write. The element width can be 8, 16, 32 or 64 bits. Elements are packed tightly from the least significant end of a base register. When one register fills up, the next element goes into the following register number. The block works out the target register and the byte offset from the base register, the element index and the width. It moves the result into the matching byte lanes and builds an 8-bit byte-enable mask from the element's predicate bit. The mask is fanned out to as many lanes as the element occupies.

The register file is a byte-writable array. Each byte lane has its own write enable, so a partial write leaves the other bytes of the register as they were. A write lands on the rising clock edge. A separate read port returns the contents of any register combinationally.

An element whose computed register number lies past the last register writes nothing. For such an element an error pulse is raised for one cycle. Elements arrive on a valid/ready stream. `in_ready` is high at all times outside reset, since the single write port finishes every accepted element in the cycle it is accepted. There is therefore never back-pressure during operation. An element is accepted on a rising edge where both `in_valid` and `in_ready` are high. While reset is asserted, `in_ready` is low and nothing is accepted.

Top module: `elem_reg_writer`

## Requirements
- R1: After reset every one of the 32 registers reads zero and `err_pulse` is low.
- R2: With width code 2'b00 (64-bit) and predicate set, the whole of register base+index is replaced by `in_data`.
- R3: With width code 2'b11 (8-bit) and predicate set, only byte (index mod 8) of register base+index/8 is written, taking `in_data[7:0]`; the other seven bytes keep their values.
- R4: With width code 2'b10 (16-bit) and predicate set, two bytes starting at byte offset (2·index mod 8) of register base+2·index/8 are written from `in_data[15:0]`. For example, element 4 writes only bits 15:0 of register base+1.
- R5: With width code 2'b01 (32-bit) and predicate set, four bytes starting at byte offset (4·index mod 8) of register base+4·index/8 are written from `in_data[31:0]`.
- R6: An accepted element whose predicate bit is 0 changes no register.
- R7: When base + (index·bytes-per-element)/8 is 32 or more, no register changes, and `err_pulse` is high in exactly the cycle after acceptance, then low again unless another such element is accepted.
- R8: A write is visible on `rd_data` for the addressed register right after the accepting rising edge.
- R9: While `in_valid` is low, no register changes, whatever the other inputs carry.
- R10: `in_ready` is low during reset and high in every cycle out of reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Element present on the input stream |
| in_ready | output | 1 | Block can accept an element |
| in_base | input | 5 | Base register number of the vector |
| in_index | input | 8 | Element index within the vector |
| in_ew | input | 2 | Element width code: 00=64, 01=32, 10=16, 11=8 bits |
| in_pred | input | 1 | Predicate bit of this element |
| in_data | input | 64 | Element result, right-aligned |
| rd_addr | input | 5 | Read port register number |
| rd_data | output | 64 | Read port data (combinational) |
| err_pulse | output | 1 | One-cycle flag: last accepted element targeted a register past the end |

## Verification
The hardest case to reach is a narrow element that runs over into the next register while that register already holds data. Only then does the bench show that the untouched bytes survive. To reach it, a register is first filled with a full-width write of all ones. A 16-bit element whose index carries it over the register boundary is then written on top, and every byte of both registers is compared. The out-of-range case is reached the same way: a base near the top of the file is combined with an index that steps past the last register. The bench then follows `err_pulse` over two cycles and checks that the whole file is unchanged.

// File: rtl/ewr_pkg.sv
package ewr_pkg;
  localparam int unsigned DATA_W   = 64;
  localparam int unsigned LANES    = DATA_W / 8;
  localparam int unsigned OFF_W    = $clog2(LANES);

  typedef enum logic [1:0] {
    EW_64 = 2'b00,
    EW_32 = 2'b01,
    EW_16 = 2'b10,
    EW_8  = 2'b11
  } elem_width_e;

  // log2 of bytes per element for a width code
  function automatic logic [1:0] width_log2_bytes(elem_width_e ew);
    return 2'd3 - ew;
  endfunction
endpackage

// File: rtl/ewr_lane_calc.sv
module ewr_lane_calc
  import ewr_pkg::*;
#(
  parameter int unsigned NREGS = 32,
  parameter int unsigned AW    = $clog2(NREGS),
  parameter int unsigned IDXW  = 8
) (
  input  logic [AW-1:0]    base,
  input  logic [IDXW-1:0]  index,
  input  elem_width_e      ew,
  output logic [AW-1:0]    tgt_reg,
  output logic [OFF_W-1:0] byte_off,
  output logic             oob
);
  localparam int unsigned POSW = IDXW + OFF_W;
  localparam int unsigned SUMW = ((IDXW > AW) ? IDXW : AW) + 1;

  logic [POSW-1:0] byte_pos;
  logic [SUMW-1:0] reg_sum;

  always_comb begin
    byte_pos = {{OFF_W{1'b0}}, index} << width_log2_bytes(ew);
    byte_off = byte_pos[OFF_W-1:0];
    reg_sum  = SUMW'(base) + SUMW'(byte_pos[POSW-1:OFF_W]);
    oob      = (reg_sum >= SUMW'(NREGS));
    tgt_reg  = reg_sum[AW-1:0];
  end
endmodule

// File: rtl/ewr_mask_expand.sv
module ewr_mask_expand
  import ewr_pkg::*;
(
  input  logic               fire,
  input  logic               pred,
  input  logic               oob,
  input  elem_width_e        ew,
  input  logic [OFF_W-1:0]   byte_off,
  input  logic [DATA_W-1:0]  data,
  output logic [LANES-1:0]   byte_we,
  output logic [DATA_W-1:0]  lane_data
);
  logic [LANES-1:0] span;

  always_comb begin
    unique case (ew)
      EW_64:   span = {LANES{1'b1}};
      EW_32:   span = LANES'(8'h0F);
      EW_16:   span = LANES'(8'h03);
      default: span = LANES'(8'h01);
    endcase
    byte_we   = (fire && pred && !oob) ? (span << byte_off) : '0;
    lane_data = data << {byte_off, 3'b000};
  end
endmodule

// File: rtl/ewr_regfile.sv
module ewr_regfile
  import ewr_pkg::*;
#(
  parameter int unsigned NREGS = 32,
  parameter int unsigned AW    = $clog2(NREGS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LANES-1:0]  we,
  input  logic [AW-1:0]     wa,
  input  logic [DATA_W-1:0] wd,
  input  logic [AW-1:0]     ra,
  output logic [DATA_W-1:0] rd
);
  for (genvar b = 0; b < LANES; b++) begin : g_lane
    logic [7:0] lane_mem [NREGS];

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        for (int r = 0; r < NREGS; r++) lane_mem[r] <= '0;
      end else if (we[b]) begin
        lane_mem[wa] <= wd[b*8 +: 8];
      end
    end

    assign rd[b*8 +: 8] = lane_mem[ra];
  end
endmodule

// File: rtl/elem_reg_writer.sv
module elem_reg_writer
  import ewr_pkg::*;
#(
  parameter int unsigned NREGS = 32,
  parameter int unsigned AW    = $clog2(NREGS),
  parameter int unsigned IDXW  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [AW-1:0]     in_base,
  input  logic [IDXW-1:0]   in_index,
  input  logic [1:0]        in_ew,
  input  logic              in_pred,
  input  logic [DATA_W-1:0] in_data,
  input  logic [AW-1:0]     rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              err_pulse
);
  elem_width_e       ew;
  logic              fire;
  logic [AW-1:0]     tgt_reg;
  logic [OFF_W-1:0]  byte_off;
  logic              tgt_oob;
  logic [LANES-1:0]  byte_we;
  logic [DATA_W-1:0] lane_data;
  logic              err_q;

  assign ew       = elem_width_e'(in_ew);
  assign in_ready = rst_n;
  assign fire     = in_valid && in_ready;

  ewr_lane_calc #(.NREGS(NREGS), .AW(AW), .IDXW(IDXW)) u_calc (
    .base     (in_base),
    .index    (in_index),
    .ew       (ew),
    .tgt_reg  (tgt_reg),
    .byte_off (byte_off),
    .oob      (tgt_oob)
  );

  ewr_mask_expand u_mask (
    .fire      (fire),
    .pred      (in_pred),
    .oob       (tgt_oob),
    .ew        (ew),
    .byte_off  (byte_off),
    .data      (in_data),
    .byte_we   (byte_we),
    .lane_data (lane_data)
  );

  ewr_regfile #(.NREGS(NREGS), .AW(AW)) u_rf (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (byte_we),
    .wa    (tgt_reg),
    .wd    (lane_data),
    .ra    (rd_addr),
    .rd    (rd_data)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) err_q <= 1'b0;
    else        err_q <= fire && tgt_oob;
  end

  assign err_pulse = err_q;
endmodule

// File: rtl/ewr_checker.sv
module ewr_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       in_valid,
  input logic       in_ready,
  input logic [1:0] in_ew,
  input logic       in_pred,
  input logic [7:0] byte_we,
  input logic       oob,
  input logic       err_pulse
);
  assert_ready_out_of_reset_R10: assert property (
    @(posedge clk) disable iff (!rst_n) in_ready);

  assert_no_write_idle_R9: assert property (
    @(posedge clk) disable iff (!rst_n) !in_valid |-> (byte_we == 8'h00));

  assert_pred_clear_no_write_R6: assert property (
    @(posedge clk) disable iff (!rst_n) (in_valid && !in_pred) |-> (byte_we == 8'h00));

  assert_oob_no_write_R7: assert property (
    @(posedge clk) disable iff (!rst_n) oob |-> (byte_we == 8'h00));

  assert_oob_raises_err_R7: assert property (
    @(posedge clk) disable iff (!rst_n) (in_valid && in_ready && oob) |=> err_pulse);

  assert_err_has_cause_R7: assert property (
    @(posedge clk) disable iff (!rst_n) err_pulse |-> $past(in_valid && oob));

  // enable count follows width: R2 R3 R4 R5
  assert_lane_count_R3: assert property (
    @(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready && in_pred && !oob) |-> ($countones(byte_we) == (4'd8 >> in_ew)));
endmodule

bind elem_reg_writer ewr_checker u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .in_ew     (in_ew),
  .in_pred   (in_pred),
  .byte_we   (byte_we),
  .oob       (tgt_oob),
  .err_pulse (err_pulse)
);

// File: tb/tb_elem_reg_writer.sv
`timescale 1ns/1ps
module tb_elem_reg_writer;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic        in_ready;
  logic [4:0]  in_base;
  logic [7:0]  in_index;
  logic [1:0]  in_ew;
  logic        in_pred;
  logic [63:0] in_data;
  logic [4:0]  rd_addr;
  logic [63:0] rd_data;
  logic        err_pulse;

  int n_tests = 0;
  int n_fail  = 0;
  logic [63:0] model [32];

  always #10 clk = ~clk;  // 50 MHz

  elem_reg_writer dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_base(in_base), .in_index(in_index), .in_ew(in_ew), .in_pred(in_pred),
    .in_data(in_data), .rd_addr(rd_addr), .rd_data(rd_data), .err_pulse(err_pulse)
  );

  task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic check_reg(input string tag, input int r);
    rd_addr = 5'(r);
    #1;
    chk(tag, rd_data, model[r]);
  endtask

  task automatic check_all(input string tag);
    for (int r = 0; r < 32; r++) check_reg(tag, r);
  endtask

  // drive at negedge; write lands at next posedge; back at next negedge
  task automatic put(input int base, input int idx, input int ew, input bit pred,
                     input logic [63:0] data, input bit valid);
    int nb, pos, tr, off;
    case (ew)
      0: nb = 8; 1: nb = 4; 2: nb = 2; default: nb = 1;
    endcase
    pos = idx * nb;
    tr  = base + pos / 8;
    off = pos % 8;
    in_valid = valid; in_base = 5'(base); in_index = 8'(idx);
    in_ew = 2'(ew); in_pred = pred; in_data = data;
    @(posedge clk);
    if (valid && pred && tr < 32)
      for (int k = 0; k < nb; k++) model[tr][(off+k)*8 +: 8] = data[k*8 +: 8];
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic test_reset;
    rst_n = 1'b0; in_valid = 1'b0; in_base = '0; in_index = '0;
    in_ew = '0; in_pred = 1'b0; in_data = '0; rd_addr = '0;
    for (int r = 0; r < 32; r++) model[r] = '0;
    repeat (3) @(negedge clk);
    chk("R10 ready in reset", 64'(in_ready), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R10 ready", 64'(in_ready), 64'd1);
    chk("R1 err", 64'(err_pulse), 64'd0);
    check_all("R1 reset contents");
  endtask

  task automatic test_w64;
    put(3, 2, 0, 1'b1, 64'hDEAD_BEEF_0123_4567, 1'b1);
    check_reg("R8 readback", 5);
    check_reg("R2 full word", 5);
    check_reg("R2 neighbour", 4);
  endtask

  task automatic test_w8;
    for (int i = 0; i < 10; i++) put(10, i, 3, 1'b1, 64'hFFFF_FFFF_FFFF_FF00 | 64'(8'hA0 + i), 1'b1);
    check_reg("R3 first reg", 10);
    check_reg("R3 spill reg", 11);
    check_reg("R3 untouched", 12);
  endtask

  task automatic test_w16;
    put(21, 0, 0, 1'b1, 64'hFFFF_FFFF_FFFF_FFFF, 1'b1);
    put(20, 4, 2, 1'b1, 64'hAAAA_AAAA_AAAA_1234, 1'b1);
    check_reg("R4 elem4 low half", 21);
    chk("R4 expected value", model[21], 64'hFFFF_FFFF_FFFF_1234);
    put(20, 2, 2, 1'b1, 64'h5678, 1'b1);
    check_reg("R4 mid lane", 20);
  endtask

  task automatic test_w32;
    put(0, 3, 1, 1'b1, 64'h1111_1111_CAFE_F00D, 1'b1);
    check_reg("R5 upper word", 1);
    put(0, 0, 1, 1'b1, 64'h0BAD_F00D, 1'b1);
    check_reg("R5 lower word", 0);
  endtask

  task automatic test_pred0;
    put(3, 2, 0, 1'b0, 64'h0, 1'b1);
    check_reg("R6 pred clear 64", 5);
    put(20, 4, 2, 1'b0, 64'h0, 1'b1);
    check_reg("R6 pred clear 16", 21);
  endtask

  task automatic test_oob;
    put(31, 1, 0, 1'b1, 64'h7777_7777_7777_7777, 1'b1);
    chk("R7 err raised", 64'(err_pulse), 64'd1);
    @(negedge clk);
    chk("R7 err single", 64'(err_pulse), 64'd0);
    put(30, 16, 3, 1'b1, 64'h55, 1'b1);
    chk("R7 err byte case", 64'(err_pulse), 64'd1);
    check_all("R7 no write");
  endtask

  task automatic test_novalid;
    put(3, 2, 0, 1'b1, 64'h9999_9999_9999_9999, 1'b0);
    check_reg("R9 idle", 5);
    chk("R9 err", 64'(err_pulse), 64'd0);
  endtask

  initial begin
    test_reset();
    test_w64();
    test_w8();
    test_w16();
    test_w32();
    test_pred0();
    test_oob();
    test_novalid();
    check_all("R8 final contents");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule